// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits between the pins of an SPI slave and the slave's serial engine. Its job is to carry out a pause requested through an active-low hold input. It samples the serial clock, data-in, chip-select and hold pins into the system clock domain through a synchronizer whose depth is a parameter. From these samples it produces gated rising-edge and falling-edge strobes for the engine. It also produces an output-enable override for the serial data-out driver.

While a pause is in force, no clock edge reaches the engine, so the engine's bit and byte counters stay where they were. The transfer then carries on from the exact bit at which it stopped. Both entering and leaving the pause are qualified by the serial clock being low. If the hold level changes while the clock is high, the change takes effect only once the clock is low again. The serial data-out driver is disabled whenever hold is low, while paused, and while deselected. Deselecting the slave clears a pause and resets the engine.

Top module: `spi_hold_gate`

## Requirements
- R1: While `paused` is 1, `sckRiseStb` and `sckFallStb` stay 0. Serial clock pulses given during a pause are never counted by the engine, so the number of rising strobes over a transfer equals the number of clock rises made outside the pause.
- R2: With the slave selected (`csNIn`=0), hold low together with clock low at the synchronized sample sets `paused` on the next clock. The pause can start only while selected.
- R3: Hold low while the clock is high does not pause. The pause begins when the synchronized clock falls, and that falling edge is not passed to the engine. If hold returns high before the clock falls, no pause happens.
- R4: A pause ends only when hold is high and the clock is low at the synchronized sample. A hold release made while the clock is high keeps `paused` at 1 until the clock is low. The resume cycle passes no strobe.
- R5: `soOe` is 0 whenever the synchronized hold is low, whether or not a pause has started, and whenever `paused` is 1. Otherwise, while selected, it follows `engSoEn`.
- R6: While `csNIn` is high, `engRst` is 1, `paused` is cleared on the next clock, `soOe` is 0 and no strobe is produced. A deselect during a pause ends the pause.
- R7: `siOut` presents the synchronized data-in level unchanged.
- R8: Every pin affects the outputs after exactly SYNC_DEPTH clock edges. `paused` follows one edge later, because it is held in a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sckIn | input | 1 | Serial clock pin |
| siIn | input | 1 | Serial data-in pin |
| csNIn | input | 1 | Active-low chip-select pin |
| holdNIn | input | 1 | Active-low hold pin |
| engSoEn | input | 1 | Data-out enable requested by the serial engine |
| sckRiseStb | output | 1 | Gated one-cycle strobe on a serial clock rise |
| sckFallStb | output | 1 | Gated one-cycle strobe on a serial clock fall |
| siOut | output | 1 | Synchronized data-in level for the engine |
| engRst | output | 1 | Engine reset while deselected |
| soOe | output | 1 | Final enable for the data-out driver |
| paused | output | 1 | Pause state |

## Verification
Two events can land in the same cycle. The first is the start of a pause, which is the same cycle in which a serial clock fall would otherwise be passed to the engine. The second is the end of a pause, which can coincide with a clock fall that follows a rise made while paused. The bench provokes the first by lowering hold while the clock is high and then dropping the clock. It provokes the second by releasing hold while the clock is high and then dropping the clock. In both cases it judges the outcome by the falling-strobe count, which must not move, and by the cycle in which `paused` changes. A behavioural model compares every output on every clock.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  // One synchronized sample of the serial pins
  typedef struct packed {
    logic sck;
    logic si;
    logic csN;
    logic holdN;
  } pinSample_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic passEdges;
    logic allowSo;
    logic engineReset;
  } holdCtl_t;

  localparam pinSample_t PINS_IDLE = '{sck: 1'b0, si: 1'b0, csN: 1'b1, holdN: 1'b1};

endpackage

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sckLvl,
  input  logic     csNLvl,
  input  logic     holdNLvl,
  output holdCtl_t ctl,
  output logic     paused
);

  logic selected;
  logic pauseNext;

  always_comb begin
    selected = !csNLvl;
    if (!selected) begin
      pauseNext = 1'b0;
    end else if (paused) begin
      // leave only with hold released and clock low
      pauseNext = !(holdNLvl && !sckLvl);
    end else begin
      // enter only with hold asserted and clock low
      pauseNext = !holdNLvl && !sckLvl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) paused <= 1'b0;
    else       paused <= pauseNext;
  end

  always_comb begin
    ctl.passEdges   = selected && !paused && !pauseNext;
    ctl.allowSo     = selected && holdNLvl && !paused && !pauseNext;
    ctl.engineReset = !selected;
  end

endmodule

// File: rtl/spi_hold_dp.sv
module spi_hold_dp
  import spi_hold_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
)(
  input  logic       clk,
  input  logic       rstN,
  input  pinSample_t pinsIn,
  input  holdCtl_t   ctl,
  input  logic       engSoEn,
  output pinSample_t lvl,
  output logic       sckRiseStb,
  output logic       sckFallStb,
  output logic       siOut,
  output logic       engRst,
  output logic       soOe
);

  localparam int LAST = SYNC_DEPTH - 1;

  pinSample_t stage [SYNC_DEPTH];
  logic       sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_DEPTH; i++) stage[i] <= PINS_IDLE;
      sckPrev <= 1'b0;
    end else begin
      stage[0] <= pinsIn;
      for (int i = 1; i < SYNC_DEPTH; i++) stage[i] <= stage[i-1];
      sckPrev <= stage[LAST].sck;
    end
  end

  assign lvl = stage[LAST];

  always_comb begin
    sckRiseStb = lvl.sck && !sckPrev && ctl.passEdges;
    sckFallStb = !lvl.sck && sckPrev && ctl.passEdges;
    siOut      = lvl.si;
    engRst     = ctl.engineReset;
    soOe       = engSoEn && ctl.allowSo;
  end

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import spi_hold_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
)(
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic siIn,
  input  logic csNIn,
  input  logic holdNIn,
  input  logic engSoEn,
  output logic sckRiseStb,
  output logic sckFallStb,
  output logic siOut,
  output logic engRst,
  output logic soOe,
  output logic paused
);

  pinSample_t pinsIn;
  pinSample_t lvl;
  holdCtl_t   ctl;

  assign pinsIn = '{sck: sckIn, si: siIn, csN: csNIn, holdN: holdNIn};

  spi_hold_dp #(.SYNC_DEPTH(SYNC_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .pinsIn(pinsIn), .ctl(ctl), .engSoEn(engSoEn),
    .lvl(lvl), .sckRiseStb(sckRiseStb), .sckFallStb(sckFallStb),
    .siOut(siOut), .engRst(engRst), .soOe(soOe)
  );

  spi_hold_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sckLvl(lvl.sck), .csNLvl(lvl.csN),
    .holdNLvl(lvl.holdN), .ctl(ctl), .paused(paused)
  );

endmodule

// File: rtl/spi_hold_chk.sv
module spi_hold_chk (
  input logic clk,
  input logic rstN,
  input logic sckRiseStb,
  input logic sckFallStb,
  input logic engRst,
  input logic soOe,
  input logic paused
);

  assert_no_edge_paused_R1: assert property (@(posedge clk) disable iff (!rstN)
    paused |-> (!sckRiseStb && !sckFallStb));

  assert_entry_selected_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(paused) |-> $past(!engRst));

  assert_quiet_out_paused_R5: assert property (@(posedge clk) disable iff (!rstN)
    paused |-> !soOe);

  assert_deselect_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    engRst |=> !paused);

  assert_deselect_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    engRst |-> (!soOe && !sckRiseStb && !sckFallStb));

endmodule

bind spi_hold_gate spi_hold_chk u_chk (
  .clk(clk), .rstN(rstN), .sckRiseStb(sckRiseStb), .sckFallStb(sckFallStb),
  .engRst(engRst), .soOe(soOe), .paused(paused)
);

// File: tb/spi_hold_gate_tb.sv
module spi_hold_gate_tb;

  localparam int SD = 2;
  localparam int H  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, siIn = 1'b0, csNIn = 1'b1, holdNIn = 1'b1, engSoEn = 1'b1;
  logic sckRiseStb, sckFallStb, siOut, engRst, soOe, paused;

  int checks = 0;
  int errors = 0;
  int riseCnt = 0;
  int fallCnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_hold_gate #(.SYNC_DEPTH(SD)) u_dut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .siIn(siIn), .csNIn(csNIn),
    .holdNIn(holdNIn), .engSoEn(engSoEn), .sckRiseStb(sckRiseStb),
    .sckFallStb(sckFallStb), .siOut(siOut), .engRst(engRst), .soOe(soOe),
    .paused(paused)
  );

  // Reference model: pin history, newest first, as {sck, si, csN, holdN}
  logic [3:0] hist[$];
  bit mPause = 1'b0;

  function automatic bit modelNext(bit cur, logic [3:0] p);
    bit s = p[3];
    bit cs = p[1];
    bit h = p[0];
    if (cs) return 1'b0;
    if (cur) return !(h && !s);
    return !h && !s;
  endfunction

  initial begin
    for (int i = 0; i <= SD; i++) hist.push_front(4'b0011);
  end

  always @(posedge clk) begin
    if (rstN) begin
      mPause = modelNext(mPause, hist[SD-1]);
      hist.push_front({sckIn, siIn, csNIn, holdNIn});
      void'(hist.pop_back());
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [3:0] nowP, oldP;
      bit gate, eRise, eFall, eOe;
      nowP  = hist[SD-1];
      oldP  = hist[SD];
      gate  = !nowP[1] && !mPause && !modelNext(mPause, nowP);
      eRise = nowP[3] && !oldP[3] && gate;
      eFall = !nowP[3] && oldP[3] && gate;
      eOe   = engSoEn && nowP[0] && gate;
      check("R1/R3/R4 strobes", {6'd0, sckRiseStb, sckFallStb}, {6'd0, eRise, eFall});
      check("R2/R4 paused", {7'd0, paused}, {7'd0, mPause});
      check("R5 soOe", {7'd0, soOe}, {7'd0, eOe});
      check("R6 engRst", {7'd0, engRst}, {7'd0, nowP[1]});
      check("R7 siOut", {7'd0, siOut}, {7'd0, nowP[2]});
      if (sckRiseStb) riseCnt++;
      if (sckFallStb) fallCnt++;
    end
  end

  task automatic go(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse(bit d);
    siIn = d; sckIn = 1'b1; go(H);
    sckIn = 1'b0; go(H);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    int f0;
    go(4);
    check("R6 reset paused", {7'd0, paused}, 8'd0);
    check("R6 reset engRst", {7'd0, engRst}, 8'd1);
    check("R6 reset soOe", {7'd0, soOe}, 8'd0);
    rstN = 1'b1; go(3);

    csNIn = 1'b0; go(4);
    check("R6 selected engRst", {7'd0, engRst}, 8'd0);
    check("R5 selected soOe", {7'd0, soOe}, 8'd1);
    for (int i = 7; i >= 0; i--) pulse(8'hA5 >> i);
    go(2);
    check("R1 first byte rises", riseCnt[7:0], 8'd8);

    // R8 latency and R2 entry with clock low
    holdNIn = 1'b0; go(SD-1);
    check("R8 soOe before latency", {7'd0, soOe}, 8'd1);
    go(1);
    check("R5 soOe hold low", {7'd0, soOe}, 8'd0);
    check("R8 paused one later", {7'd0, paused}, 8'd0);
    go(1);
    check("R2 paused set", {7'd0, paused}, 8'd1);

    for (int i = 0; i < 3; i++) pulse(1'b1);
    go(2);
    check("R1 pulses ignored", riseCnt[7:0], 8'd8);

    // R4 release while clock high is deferred
    f0 = fallCnt;
    sckIn = 1'b1; go(H);
    holdNIn = 1'b1; go(4);
    check("R4 still paused", {7'd0, paused}, 8'd1);
    sckIn = 1'b0; go(4);
    check("R4 resumed", {7'd0, paused}, 8'd0);
    check("R4 no fall on resume", fallCnt[7:0], f0[7:0]);
    check("R1 no rise in pause", riseCnt[7:0], 8'd8);

    // R3 hold while clock high, entry at the fall
    sckIn = 1'b1; go(4);
    holdNIn = 1'b0; go(4);
    check("R3 no pause clock high", {7'd0, paused}, 8'd0);
    check("R5 soOe pending", {7'd0, soOe}, 8'd0);
    f0 = fallCnt;
    sckIn = 1'b0; go(4);
    check("R3 pause at fall", {7'd0, paused}, 8'd1);
    check("R3 fall suppressed", fallCnt[7:0], f0[7:0]);
    holdNIn = 1'b1; go(4);
    check("R4 resume clock low", {7'd0, paused}, 8'd0);
    for (int i = 0; i < 7; i++) pulse(1'b0);
    go(2);
    check("R1 second byte total", riseCnt[7:0], 8'd16);

    // R3 cancelled pending entry
    sckIn = 1'b1; go(3);
    holdNIn = 1'b0; go(3);
    holdNIn = 1'b1; go(3);
    sckIn = 1'b0; go(4);
    check("R3 cancelled entry", {7'd0, paused}, 8'd0);

    // R6 deselect during pause
    holdNIn = 1'b0; go(4);
    check("R2 paused again", {7'd0, paused}, 8'd1);
    csNIn = 1'b1; go(4);
    check("R6 pause cleared", {7'd0, paused}, 8'd0);
    check("R6 engRst on deselect", {7'd0, engRst}, 8'd1);
    holdNIn = 1'b1;
    f0 = riseCnt;
    pulse(1'b1); go(2);
    check("R6 no strobe deselected", riseCnt[7:0], f0[7:0]);

    // R7 data passthrough
    csNIn = 1'b0; siIn = 1'b1; go(SD);
    check("R7 siOut high", {7'd0, siOut}, 8'd1);
    siIn = 1'b0; go(SD);
    check("R7 siOut low", {7'd0, siOut}, 8'd0);
    engSoEn = 1'b0; go(1);
    check("R5 follows engine", {7'd0, soOe}, 8'd0);
    go(4);
    finishRun();
  end

endmodule